// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, per frame, whether the frame is kept or discarded. It watches the first six bytes of each frame, which carry the destination address, and the frame length that arrives with the first byte. It sorts the frame into unicast, broadcast, multicast or IP multicast. It then applies a station-address match, broadcast and multicast reject switches, four exact-match multicast entries, a promiscuous bypass, a length window for tagged frames and an optional second filtering stage. That second stage uses a 32768-bit lookup table indexed from the last two address bytes.

The decision is a single-cycle pulse with an accept flag and the frame class. Two event pulses, one for kept frames and one for discarded frames, come out in the same cycle, ready to feed an interrupt status register. Frame storage and FCS checking happen elsewhere. The multicast entries and the lookup table are written through simple write ports. All other settings are level inputs and are expected to stay still while a frame is in flight.

The control is a three-state machine:
- ST_IDLE waits for a start-of-frame byte.
- ST_ADDR collects the address bytes.
- ST_BODY lets the rest of the frame pass until its end marker.

Transitions:
- IDLE→ADDR on a start byte that is not also an end byte.
- ADDR→BODY on the sixth byte when it is not an end byte.
- ADDR→IDLE on an end byte, either the sixth byte or an early one.
- BODY→IDLE on the end byte.
- From any state, a start byte restarts collection. A start byte that is also an end byte is decided as a runt and leads to IDLE.

Top module: `rx_addr_filter`

## Requirements
- R1: The class is reported on `dec_class`:
  - 0 (unicast) when bit 0 of the first address byte is 0.
  - 1 (broadcast) when all six address bytes are FF.
  - 3 (IP multicast) when the first three bytes are 01-00-5E.
  - 2 (multicast) otherwise.
- R2: Without promiscuous mode, a unicast frame passes the basic stage only when the address equals the station pair. Address bytes 0..3 are compared with `cfg_sta_lo`, with byte 0 at bits 7:0. Bytes 4..5 are compared with `cfg_sta_hi`, with byte 4 at bits 7:0.
- R3: A broadcast frame is dropped when `cfg_bc_reject` is 1 and otherwise passes the basic stage.
- R4: Without promiscuous mode, a multicast or IP-multicast frame is dropped when `cfg_mc_reject` is 1. Otherwise it passes the basic stage only if it equals one of four stored entries, compared in the same byte order as R2. Entry `mc_wr_sel` is written from `mc_wr_lo`/`mc_wr_hi` when `mc_wr_en` is 1.
- R5: When `cfg_promisc` is 1, the basic stage (R2–R4) passes every frame.
- R6: When neither `cfg_jumbo_en` nor `cfg_vlan_en` is 1, a frame whose length is greater than 1518 and at most 1522 is dropped. Other lengths are not dropped for length.
- R7: The extended stage is active only when both `cfg_ext_fn_en` and `cfg_ext_mc_en` are 1. When it is active, all of the following apply:
  - A unicast frame must also equal the extended pair `cfg_xsta_lo`/`cfg_xsta_hi`.
  - A broadcast frame obeys `cfg_bc_reject`.
  - An IP-multicast frame is kept only if table bit `idx[4:0]` of word `idx[14:5]` is 1, where idx = {byte4[6:0], byte5}. Table words are written through `tbl_wr_*`.
  - Any other multicast frame passes this stage.
- R8: `dec_valid` pulses for exactly one cycle per frame of six or more bytes, in the cycle after the sixth byte is taken. In that same cycle, `evt_rx_done` pulses if the frame is accepted and `evt_rx_reject` pulses if it is dropped.
- R9: A frame whose end marker comes before its sixth byte is dropped with class 0. The decision pulses in the cycle after the end byte.
- R10: During and directly after reset, `dec_valid`, `dec_accept`, `evt_rx_done` and `evt_rx_reject` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stream byte is present this cycle |
| in_sop | input | 1 | The byte is the first of a frame |
| in_eop | input | 1 | The byte is the last of a frame |
| in_data | input | 8 | Stream byte |
| in_len | input | 16 | Frame length in bytes, sampled with the first byte |
| cfg_promisc | input | 1 | Bypass the basic address stage |
| cfg_mc_reject | input | 1 | Drop multicast in the basic stage |
| cfg_bc_reject | input | 1 | Drop broadcast |
| cfg_ext_fn_en | input | 1 | First of two enables for the extended stage |
| cfg_ext_mc_en | input | 1 | Second of two enables for the extended stage |
| cfg_jumbo_en | input | 1 | Lift the length window |
| cfg_vlan_en | input | 1 | Allow tagged lengths up to 1522 |
| cfg_sta_lo | input | 32 | Station address bytes 0..3 |
| cfg_sta_hi | input | 16 | Station address bytes 4..5 |
| cfg_xsta_lo | input | 32 | Extended station address bytes 0..3 |
| cfg_xsta_hi | input | 16 | Extended station address bytes 4..5 |
| mc_wr_en | input | 1 | Write a multicast entry |
| mc_wr_sel | input | 2 | Entry number to write |
| mc_wr_lo | input | 32 | Entry bytes 0..3 |
| mc_wr_hi | input | 16 | Entry bytes 4..5 |
| tbl_wr_en | input | 1 | Write a lookup table word |
| tbl_wr_addr | input | 10 | Table word number |
| tbl_wr_data | input | 32 | Table word value |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame kept (valid with `dec_valid`) |
| dec_class | output | 2 | Frame class (R1 encoding) |
| evt_rx_done | output | 1 | Kept-frame event pulse |
| evt_rx_reject | output | 1 | Dropped-frame event pulse |

## Verification
A byte counter or state register that slips shows up at the ports one cycle early or late. The decision pulse then moves off the cycle after the sixth byte, or appears twice in one frame, or never appears. Each frame's pulse position and pulse count expose this within that same frame. A wrong captured address byte, a swapped byte order in a compare, or a mis-sliced table index shows up as a wrong accept flag or class on the very frame that uses it. The vectors therefore pair addresses that differ only in the last byte, in the masked top bit of byte 4, or in the entry that was overwritten.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_BCAST = 2'd1,
        CLS_MCAST = 2'd2,
        CLS_IPMC  = 2'd3
    } frame_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_BODY = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [15:0] hi;
        logic [31:0] lo;
    } addr_pair_t;

    localparam int ADDR_BYTES = 6;
    localparam logic [23:0] IPMC_PREFIX = 24'h5E0001;

endpackage

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp
    import rxf_pkg::*;
(
    input  logic [47:0] dst,
    input  addr_pair_t  pair,
    output logic        hit
);
    // Byte k of the destination sits at dst[8k+7:8k], so the pair compares directly
    always_comb hit = (dst == {pair.hi, pair.lo});
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
    parameter int IDX_W  = 15,
    parameter int WORD_W = 32,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int WADR_W = IDX_W - BIT_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WADR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_bit
);
    localparam int WORDS = 1 << WADR_W;

    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_comb rd_bit = mem[rd_idx[IDX_W-1:BIT_W]][rd_idx[BIT_W-1:0]];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int N_MCAST      = 4,
    parameter int BASE_MAX_LEN = 1518,
    parameter int TAG_BYTES    = 4,
    parameter int HASH_IDX_W   = 15,
    localparam int MC_SEL_W    = $clog2(N_MCAST),
    localparam int TBL_ADDR_W  = HASH_IDX_W - 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic [7:0]            in_data,
    input  logic [LEN_W-1:0]      in_len,
    input  logic                  cfg_promisc,
    input  logic                  cfg_mc_reject,
    input  logic                  cfg_bc_reject,
    input  logic                  cfg_ext_fn_en,
    input  logic                  cfg_ext_mc_en,
    input  logic                  cfg_jumbo_en,
    input  logic                  cfg_vlan_en,
    input  logic [31:0]           cfg_sta_lo,
    input  logic [15:0]           cfg_sta_hi,
    input  logic [31:0]           cfg_xsta_lo,
    input  logic [15:0]           cfg_xsta_hi,
    input  logic                  mc_wr_en,
    input  logic [MC_SEL_W-1:0]   mc_wr_sel,
    input  logic [31:0]           mc_wr_lo,
    input  logic [15:0]           mc_wr_hi,
    input  logic                  tbl_wr_en,
    input  logic [TBL_ADDR_W-1:0] tbl_wr_addr,
    input  logic [31:0]           tbl_wr_data,
    output logic                  dec_valid,
    output logic                  dec_accept,
    output logic [1:0]            dec_class,
    output logic                  evt_rx_done,
    output logic                  evt_rx_reject
);
    localparam int LAST_IDX = ADDR_BYTES - 1;
    localparam int TAG_MAX_LEN = BASE_MAX_LEN + TAG_BYTES;

    rx_state_e         state, state_nx;
    logic [2:0]        cnt;
    logic [39:0]       addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              start, decide, runt;
    logic [47:0]       dst_now;
    addr_pair_t        mc_tab [N_MCAST];
    logic [N_MCAST-1:0] mc_hits;
    logic              sta_hit, xsta_hit, tbl_bit;
    logic              is_uni, is_bc, is_ipm;
    frame_cls_e        cls_c;
    logic              basic_ok, ext_on, ext_ok, len_bad, accept_c;

    // ---------------- control ----------------
    always_comb start = in_valid && in_sop;

    always_comb begin
        state_nx = state;
        decide   = 1'b0;
        runt     = 1'b0;
        if (start) begin
            runt     = in_eop;
            state_nx = in_eop ? ST_IDLE : ST_ADDR;
        end else if (in_valid) begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_ADDR: begin
                    if (cnt == 3'(LAST_IDX)) begin
                        decide   = 1'b1;
                        state_nx = in_eop ? ST_IDLE : ST_BODY;
                    end else if (in_eop) begin
                        runt     = 1'b1;
                        state_nx = ST_IDLE;
                    end
                end
                ST_BODY: if (in_eop) state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- address capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            addr_q <= '0;
            len_q  <= '0;
        end else if (start) begin
            addr_q[7:0] <= in_data;
            cnt         <= 3'd1;
            len_q       <= in_len;
        end else if (in_valid && state == ST_ADDR && cnt < 3'(LAST_IDX)) begin
            addr_q[{cnt, 3'b000} +: 8] <= in_data;
            cnt                        <= cnt + 3'd1;
        end
    end

    always_comb dst_now = {in_data, addr_q};

    // ---------------- match resources ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_MCAST; i++) mc_tab[i] <= '0;
        end else if (mc_wr_en) begin
            mc_tab[mc_wr_sel] <= '{hi: mc_wr_hi, lo: mc_wr_lo};
        end
    end

    generate
        for (genvar g = 0; g < N_MCAST; g++) begin : g_mc
            rxf_addr_cmp i_cmp (.dst(dst_now), .pair(mc_tab[g]), .hit(mc_hits[g]));
        end
    endgenerate

    rxf_addr_cmp i_sta_cmp (
        .dst(dst_now), .pair('{hi: cfg_sta_hi, lo: cfg_sta_lo}), .hit(sta_hit));
    rxf_addr_cmp i_xsta_cmp (
        .dst(dst_now), .pair('{hi: cfg_xsta_hi, lo: cfg_xsta_lo}), .hit(xsta_hit));

    rxf_hash_table #(.IDX_W(HASH_IDX_W)) i_tbl (
        .clk     (clk),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_idx  ({addr_q[32 +: HASH_IDX_W-8], in_data}),
        .rd_bit  (tbl_bit)
    );

    // ---------------- decision ----------------
    always_comb begin
        is_uni = ~dst_now[0];
        is_bc  = &dst_now;
        is_ipm = !is_uni && !is_bc && (dst_now[23:0] == IPMC_PREFIX);
        if (is_uni)      cls_c = CLS_UNI;
        else if (is_bc)  cls_c = CLS_BCAST;
        else if (is_ipm) cls_c = CLS_IPMC;
        else             cls_c = CLS_MCAST;

        if (cfg_promisc)  basic_ok = 1'b1;
        else if (is_uni)  basic_ok = sta_hit;
        else if (is_bc)   basic_ok = !cfg_bc_reject;
        else              basic_ok = !cfg_mc_reject && (|mc_hits);

        ext_on = cfg_ext_fn_en && cfg_ext_mc_en;
        if (is_uni)      ext_ok = xsta_hit;
        else if (is_bc)  ext_ok = !cfg_bc_reject;
        else if (is_ipm) ext_ok = tbl_bit;
        else             ext_ok = 1'b1;

        len_bad  = !cfg_jumbo_en && !cfg_vlan_en &&
                   (len_q > LEN_W'(BASE_MAX_LEN)) && (len_q <= LEN_W'(TAG_MAX_LEN));
        accept_c = !len_bad && basic_ok && (!ext_on || ext_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid     <= 1'b0;
            dec_accept    <= 1'b0;
            dec_class     <= CLS_UNI;
            evt_rx_done   <= 1'b0;
            evt_rx_reject <= 1'b0;
        end else begin
            dec_valid     <= decide || runt;
            dec_accept    <= decide && accept_c;
            dec_class     <= decide ? cls_c : CLS_UNI;
            evt_rx_done   <= decide && accept_c;
            evt_rx_reject <= runt || (decide && !accept_c);
        end
    end
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
    parameter int LEN_W        = 16,
    parameter int BASE_MAX_LEN = 1518,
    parameter int TAG_BYTES    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sop,
    input logic [LEN_W-1:0] in_len,
    input logic             cfg_promisc,
    input logic             cfg_mc_reject,
    input logic             cfg_bc_reject,
    input logic             cfg_jumbo_en,
    input logic             cfg_vlan_en,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic [1:0]       dec_class,
    input logic             evt_rx_done,
    input logic             evt_rx_reject
);
    logic [LEN_W-1:0] seen_len;

    always_ff @(posedge clk) begin
        if (!rst_n)                 seen_len <= '0;
        else if (in_valid && in_sop) seen_len <= in_len;
    end

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !dec_valid && !evt_rx_done && !evt_rx_reject);

    // R8
    done_with_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_done |-> dec_valid && dec_accept);

    // R8
    reject_with_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_reject |-> dec_valid && !dec_accept);

    // R8
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $onehot({evt_rx_done, evt_rx_reject}));

    // R3
    bcast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_class == 2'd1 && cfg_bc_reject |-> !dec_accept);

    // R4
    mcast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_class[1] && cfg_mc_reject && !cfg_promisc |-> !dec_accept);

    // R6
    len_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_accept && !cfg_jumbo_en && !cfg_vlan_en |->
        !((seen_len > LEN_W'(BASE_MAX_LEN)) && (seen_len <= LEN_W'(BASE_MAX_LEN + TAG_BYTES))));
endmodule

bind rx_addr_filter rxf_filter_chk #(
    .LEN_W(LEN_W), .BASE_MAX_LEN(BASE_MAX_LEN), .TAG_BYTES(TAG_BYTES)
) i_rxf_filter_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_len(in_len),
    .cfg_promisc(cfg_promisc), .cfg_mc_reject(cfg_mc_reject), .cfg_bc_reject(cfg_bc_reject),
    .cfg_jumbo_en(cfg_jumbo_en), .cfg_vlan_en(cfg_vlan_en),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_class(dec_class),
    .evt_rx_done(evt_rx_done), .evt_rx_reject(evt_rx_reject)
);

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = '0;
    logic [15:0] in_len = '0;
    logic        cfg_promisc = 0, cfg_mc_reject = 0, cfg_bc_reject = 0;
    logic        cfg_ext_fn_en = 0, cfg_ext_mc_en = 0, cfg_jumbo_en = 0, cfg_vlan_en = 0;
    logic [31:0] cfg_sta_lo = 32'h0135_0A00;
    logic [15:0] cfg_sta_hi = 16'h0302;
    logic [31:0] cfg_xsta_lo = 32'h3322_1102;
    logic [15:0] cfg_xsta_hi = 16'h5544;
    logic        mc_wr_en = 0;
    logic [1:0]  mc_wr_sel = '0;
    logic [31:0] mc_wr_lo = '0;
    logic [15:0] mc_wr_hi = '0;
    logic        tbl_wr_en = 0;
    logic [9:0]  tbl_wr_addr = '0;
    logic [31:0] tbl_wr_data = '0;
    logic        dec_valid, dec_accept, evt_rx_done, evt_rx_reject;
    logic [1:0]  dec_class;

    int n_chk = 0, n_err = 0, pulses = 0, cycles = 0;

    always #10 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (dec_valid) pulses <= pulses + 1;
    end

    // cfg bit order: {promisc, mc_reject, bc_reject, ext_fn, ext_mc, jumbo, vlan}
    typedef struct packed {
        logic [47:0] dst;
        logic [15:0] len;
        logic [6:0]  cfg;
        logic        acc;
        logic [1:0]  cls;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{48'h000A35010203, 16'd64,   7'b0000000, 1'b1, 2'd0, 4'd2},
        '{48'h000A35010204, 16'd64,   7'b0000000, 1'b0, 2'd0, 4'd2},
        '{48'hFFFFFFFFFFFF, 16'd64,   7'b0000000, 1'b1, 2'd1, 4'd3},
        '{48'hFFFFFFFFFFFF, 16'd64,   7'b0010000, 1'b0, 2'd1, 4'd3},
        '{48'h0180C200000E, 16'd64,   7'b0000000, 1'b1, 2'd2, 4'd4},
        '{48'h0180C200000E, 16'd64,   7'b0100000, 1'b0, 2'd2, 4'd4},
        '{48'h0180C200000F, 16'd64,   7'b0000000, 1'b0, 2'd2, 4'd4},
        '{48'h333300000001, 16'd64,   7'b0000000, 1'b1, 2'd2, 4'd4},
        '{48'h000A35010204, 16'd64,   7'b1000000, 1'b1, 2'd0, 4'd5},
        '{48'h0180C200000F, 16'd64,   7'b1110000, 1'b1, 2'd2, 4'd5},
        '{48'h000A35010203, 16'd1519, 7'b0000000, 1'b0, 2'd0, 4'd6},
        '{48'h000A35010203, 16'd1522, 7'b0000001, 1'b1, 2'd0, 4'd6},
        '{48'h000A35010203, 16'd1522, 7'b0000010, 1'b1, 2'd0, 4'd6},
        '{48'h000A35010203, 16'd1518, 7'b0000000, 1'b1, 2'd0, 4'd6},
        '{48'h000A35010203, 16'd1523, 7'b0000000, 1'b1, 2'd0, 4'd6},
        '{48'h01005E010203, 16'd64,   7'b1001100, 1'b1, 2'd3, 4'd7},
        '{48'h01005E7F8544, 16'd64,   7'b1001100, 1'b0, 2'd3, 4'd7},
        '{48'h01005E008203, 16'd64,   7'b1001100, 1'b1, 2'd3, 4'd7},
        '{48'h01005E010203, 16'd64,   7'b0001100, 1'b0, 2'd3, 4'd7},
        '{48'h000A35010203, 16'd64,   7'b1001100, 1'b0, 2'd0, 4'd7},
        '{48'h021122334455, 16'd64,   7'b1001100, 1'b1, 2'd0, 4'd7},
        '{48'h0180C200000F, 16'd64,   7'b1001100, 1'b1, 2'd2, 4'd7},
        '{48'hFFFFFFFFFFFF, 16'd64,   7'b1011100, 1'b0, 2'd1, 4'd7},
        '{48'h01005E7F8544, 16'd64,   7'b1001000, 1'b1, 2'd3, 4'd7},
        '{48'h01005E7F8544, 16'd64,   7'b1000100, 1'b1, 2'd3, 4'd7},
        '{48'h01005E010203, 16'd64,   7'b0000000, 1'b0, 2'd3, 4'd1},
        '{48'h01005F010203, 16'd64,   7'b1000000, 1'b1, 2'd2, 4'd1}
    };

    function automatic string req_name(input logic [3:0] rq);
        case (rq)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [6:0] c);
        {cfg_promisc, cfg_mc_reject, cfg_bc_reject, cfg_ext_fn_en,
         cfg_ext_mc_en, cfg_jumbo_en, cfg_vlan_en} = c;
    endtask

    // Decision word: {valid, accept, class[1:0], done, reject}
    task automatic send_frame(input logic [47:0] dst, input logic [15:0] len, input int nbytes,
                              input logic exp_acc, input logic [1:0] exp_cls, input string req);
        int dpos = (nbytes < 6) ? nbytes - 1 : 5;
        int p0 = pulses;
        for (int i = 0; i <= nbytes; i++) begin
            @(negedge clk);
            if (i == dpos + 1)
                check({req, " decision"}, {26'd0, dec_valid, dec_accept, dec_class, evt_rx_done, evt_rx_reject},
                      {26'd0, 1'b1, exp_acc, exp_cls, exp_acc, !exp_acc});
            if (i < nbytes) begin
                in_valid = 1'b1;
                in_sop   = (i == 0);
                in_eop   = (i == nbytes - 1);
                in_data  = (i < 6) ? dst[47 - 8*i -: 8] : 8'(i);
                in_len   = len;
            end else begin
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
            end
        end
        @(negedge clk); @(negedge clk);
        check("R8 one pulse per frame", 32'(pulses - p0), 32'd1);
    endtask

    task automatic write_mc(input logic [1:0] sel, input logic [31:0] lo, input logic [15:0] hi);
        @(negedge clk);
        mc_wr_en = 1'b1; mc_wr_sel = sel; mc_wr_lo = lo; mc_wr_hi = hi;
        @(negedge clk);
        mc_wr_en = 1'b0;
    endtask

    task automatic write_tbl(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = a; tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    initial begin
        while (cycles < 200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=<200000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: quiet outputs during reset
        check("R10 reset outputs", {28'd0, dec_valid, dec_accept, evt_rx_done, evt_rx_reject}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", {28'd0, dec_valid, dec_accept, evt_rx_done, evt_rx_reject}, 32'd0);

        write_mc(2'd2, 32'h00C2_8001, 16'h0E00);  // 01-80-C2-00-00-0E
        write_mc(2'd0, 32'h0000_3333, 16'h0100);  // 33-33-00-00-00-01
        write_tbl(10'd16, 32'h0000_0008);         // idx 0x0203
        write_tbl(10'd42, 32'h0000_0000);         // idx 0x0544 left clear

        for (int k = 0; k < NV; k++) begin
            apply_cfg(VECS[k].cfg);
            send_frame(VECS[k].dst, VECS[k].len, 8, VECS[k].acc, VECS[k].cls, req_name(VECS[k].rq));
        end

        // R9: runt frames
        apply_cfg(7'b0000000);
        send_frame(48'h000A35010203, 16'd4, 4, 1'b0, 2'd0, "R9 runt 4 bytes");
        send_frame(48'hFFFFFFFFFFFF, 16'd1, 1, 1'b0, 2'd0, "R9 runt 1 byte");
        // R8: exactly six bytes, and a long body
        send_frame(48'h000A35010203, 16'd6, 6, 1'b1, 2'd0, "R8 six bytes");
        send_frame(48'h000A35010203, 16'd40, 40, 1'b1, 2'd0, "R8 long body");
        // R4: overwrite entry 2 through its select
        write_mc(2'd2, 32'h00C2_8001, 16'h0F00);
        send_frame(48'h0180C200000E, 16'd64, 8, 1'b0, 2'd2, "R4 overwritten entry");
        send_frame(48'h0180C200000F, 16'd64, 8, 1'b1, 2'd2, "R4 new entry");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule